// File: doc/BRIEF.md
# Banked Analog-Output Board Register Interface

This block is the bus-side register file of a multichannel 12-bit analog output card. It answers a 16-bit slave bus across a 32-byte window. It holds three configuration words, the per-channel DAC code latches and an 8-bit digital output port whose direction is set per nibble. It also composes a status word from the FIFO flags supplied from outside and from its own interrupt flags. Byte offsets are decoded on address bits 4:1, and bit 0 is ignored.

Bit 7 of configuration word 1 selects the alternate register bank. While that bit is set, writes to the three lowest word offsets no longer reach storage. They produce single-cycle clear pulses for the terminal-count flag and the two interrupt flags. The same bit is the only way to reach DAC channel 0, because its offset is shared with the FIFO write port. The counter/timer, the FIFO storage, DMA and the converters lie outside the block. The FIFO appears only as strobes and as flag inputs.

Top module: `aout_bus_regs`

## Requirements
- R1: While rst_n is low, and after it is released, configuration words 1, 2 and 3 read zero, the digital output value is zero, all DAC codes are zero, all three flags are clear and every strobe is low.
- R2: A write to offset 0x0A loads configuration word 1 in the following cycle. A read of 0x0A returns the status word: bit6 FIFO half, bit5 FIFO empty, bit4 FIFO full, bit3 interrupt 2, bit2 interrupt 1, bit1 terminal-count flag, bit0 serial PROM data, and zero above bit 6.
- R3: With bank bit 7 of word 1 clear, a write to 0x00 loads the digital output value from data bits 7:0, a write to 0x02 loads word 2 and a write to 0x04 loads word 3. With the bank bit set, these registers keep their values.
- R4: With the bank bit set, a write to 0x00, 0x02 or 0x04 gives a one-cycle pulse in the next cycle on tc_clr_stb, int1_clr_stb or int2_clr_stb respectively. No pulse occurs while the bank bit is clear.
- R5: A write to offset 0x0C+2n, for channel n from 1 to NUM_CH-1, stores the code in channel n with bit 11 of data bits 11:0 inverted. The bus value is in two's complement and the stored code is offset binary.
- R6: A write to 0x0C loads channel 0 only while the bank bit is set. While the bit is clear, the write leaves channel 0 unchanged and instead pulses fifo_wr_stb for one cycle in the next cycle.
- R7: A read of 0x0C pulses fifo_clr_stb for one cycle in the next cycle. A read of 0x00 returns the digital input lines in bits 7:0 and zero above. Other offsets read zero.
- R8: Bit 2 of word 3 enables drive on digital lines 3:0 and bit 3 enables drive on lines 7:4. The output value is always presented.
- R9: A DAC write whose channel index is NUM_CH or higher changes no channel.
- R10: A flag is set after a cycle in which its event input is high and its enable in word 1 is set: bit 14 for interrupt 1, bit 15 for interrupt 2, bit 11 for terminal count. The flag stays set until the clear write of R4. When an event and a clear fall in the same cycle, the flag remains set. int_flags carries bit0 terminal count, bit1 interrupt 1 and bit2 interrupt 2.
- R11: At most one of the five strobes is high in any cycle, and each strobe lasts one cycle for each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Write access this cycle |
| bus_rd | input | 1 | Read access this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset |
| din_pins | input | 8 | Digital input lines |
| ev_tc | input | 1 | Terminal-count event |
| ev_int1 | input | 1 | Interrupt 1 event |
| ev_int2 | input | 1 | Interrupt 2 event |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| prom_bit | input | 1 | Serial PROM data bit |
| cfg1_val | output | 16 | Configuration word 1 |
| cfg2_val | output | 16 | Configuration word 2 |
| cfg3_val | output | 16 | Configuration word 3 |
| dout_val | output | 8 | Digital output value |
| dout_oe | output | 8 | Per-line drive enable |
| dac_codes | output | NUM_CH*DAC_W | Offset-binary codes, channel n at bits n*DAC_W upward |
| int_flags | output | 3 | Terminal-count, interrupt 1 and interrupt 2 flags |
| tc_clr_stb | output | 1 | Terminal-count clear pulse |
| int1_clr_stb | output | 1 | Interrupt 1 clear pulse |
| int2_clr_stb | output | 1 | Interrupt 2 clear pulse |
| fifo_wr_stb | output | 1 | FIFO write pulse |
| fifo_clr_stb | output | 1 | FIFO clear pulse |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle, and that the bus idles during reset. The one-hot strobe property depends on this, because a read and a write to different offsets at once could raise two strobes. Every bench access asserts exactly one of the two signals. Event inputs may change in any cycle, so the bench drives them freely, and sometimes in the same cycle as a clear write.

// File: rtl/aout_pkg.sv
package aout_pkg;
    localparam int WORD_W = 16;
    localparam int DIO_W  = 8;

    // word offsets (byte offset >> 1)
    localparam logic [3:0] W_DIO  = 4'd0;
    localparam logic [3:0] W_CFG2 = 4'd1;
    localparam logic [3:0] W_CFG3 = 4'd2;
    localparam logic [3:0] W_CFG1 = 4'd5;
    localparam logic [3:0] W_DAC0 = 4'd6;

    localparam int BANK_BIT = 7;
    localparam int EN_TC    = 11;
    localparam int EN_INT1  = 14;
    localparam int EN_INT2  = 15;
    localparam int OE_LO    = 2;
    localparam int OE_HI    = 3;

    typedef struct packed {
        logic       wr_dio;
        logic       wr_cfg1;
        logic       wr_cfg2;
        logic       wr_cfg3;
        logic       clr_tc;
        logic       clr_int1;
        logic       clr_int2;
        logic       fifo_wr;
        logic       fifo_clr;
        logic       dac_we;
        logic [3:0] dac_idx;
    } hit_t;

    typedef struct packed {
        logic [WORD_W-1:0] cfg1;
        logic [WORD_W-1:0] cfg2;
        logic [WORD_W-1:0] cfg3;
        logic [DIO_W-1:0]  dout;
        logic              stb_tc;
        logic              stb_int1;
        logic              stb_int2;
        logic              stb_fwr;
        logic              stb_fclr;
    } ctl_t;
endpackage

// File: rtl/aout_decode.sv
module aout_decode
    import aout_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic [4:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic       bank,
    output hit_t       hit
);
    logic [3:0] word;
    logic [3:0] idx;

    assign word = addr[4:1];
    assign idx  = word - W_DAC0;

    always_comb begin
        hit = '0;
        hit.dac_idx = idx;
        if (wr) begin
            unique case (word)
                W_DIO:   begin hit.wr_dio  = !bank; hit.clr_tc   = bank; end
                W_CFG2:  begin hit.wr_cfg2 = !bank; hit.clr_int1 = bank; end
                W_CFG3:  begin hit.wr_cfg3 = !bank; hit.clr_int2 = bank; end
                W_CFG1:  hit.wr_cfg1 = 1'b1;
                default: begin
                    if (word >= W_DAC0) begin
                        if (idx == 4'd0 && !bank) begin
                            hit.fifo_wr = 1'b1;
                        end else if (32'(idx) < NUM_CH) begin
                            hit.dac_we = 1'b1;
                        end
                    end
                end
            endcase
        end
        if (rd && word == W_DAC0) begin
            hit.fifo_clr = 1'b1;
        end
    end
endmodule

// File: rtl/aout_irq_flag.sv
module aout_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic event_in,
    input  logic clear,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q && !clear) || (event_in && enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/aout_dac_bank.sv
module aout_dac_bank #(
    parameter int NUM_CH = 6,
    parameter int DAC_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [3:0]              idx,
    input  logic [DAC_W-1:0]        wdata,
    output logic [NUM_CH*DAC_W-1:0] codes
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [DAC_W-1:0] code_d, code_q;

        always_comb begin
            code_d = code_q;
            if (we && 32'(idx) == ch) begin
                // two's complement to offset binary
                code_d = {~wdata[DAC_W-1], wdata[DAC_W-2:0]};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) code_q <= '0;
            else        code_q <= code_d;
        end

        assign codes[ch*DAC_W +: DAC_W] = code_q;
    end
endmodule

// File: rtl/aout_bus_regs.sv
module aout_bus_regs
    import aout_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DAC_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [15:0]             bus_wdata,
    output logic [15:0]             bus_rdata,
    input  logic [7:0]              din_pins,
    input  logic                    ev_tc,
    input  logic                    ev_int1,
    input  logic                    ev_int2,
    input  logic                    fifo_half,
    input  logic                    fifo_empty,
    input  logic                    fifo_full,
    input  logic                    prom_bit,
    output logic [15:0]             cfg1_val,
    output logic [15:0]             cfg2_val,
    output logic [15:0]             cfg3_val,
    output logic [7:0]              dout_val,
    output logic [7:0]              dout_oe,
    output logic [NUM_CH*DAC_W-1:0] dac_codes,
    output logic [2:0]              int_flags,
    output logic                    tc_clr_stb,
    output logic                    int1_clr_stb,
    output logic                    int2_clr_stb,
    output logic                    fifo_wr_stb,
    output logic                    fifo_clr_stb
);
    localparam int HALF = DIO_W / 2;

    ctl_t ctl_d, ctl_q;
    hit_t hit;

    aout_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .bank (ctl_q.cfg1[BANK_BIT]),
        .hit  (hit)
    );

    logic [2:0] flag_en, flag_ev, flag_clr;
    assign flag_en  = {ctl_q.cfg1[EN_INT2], ctl_q.cfg1[EN_INT1], ctl_q.cfg1[EN_TC]};
    assign flag_ev  = {ev_int2, ev_int1, ev_tc};
    assign flag_clr = {hit.clr_int2, hit.clr_int1, hit.clr_tc};

    for (genvar f = 0; f < 3; f++) begin : g_flag
        aout_irq_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (flag_en[f]),
            .event_in (flag_ev[f]),
            .clear    (flag_clr[f]),
            .flag     (int_flags[f])
        );
    end

    aout_dac_bank #(.NUM_CH(NUM_CH), .DAC_W(DAC_W)) u_dacs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hit.dac_we),
        .idx   (hit.dac_idx),
        .wdata (bus_wdata[DAC_W-1:0]),
        .codes (dac_codes)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.stb_tc   = hit.clr_tc;
        ctl_d.stb_int1 = hit.clr_int1;
        ctl_d.stb_int2 = hit.clr_int2;
        ctl_d.stb_fwr  = hit.fifo_wr;
        ctl_d.stb_fclr = hit.fifo_clr;
        if (hit.wr_cfg1) ctl_d.cfg1 = bus_wdata;
        if (hit.wr_cfg2) ctl_d.cfg2 = bus_wdata;
        if (hit.wr_cfg3) ctl_d.cfg3 = bus_wdata;
        if (hit.wr_dio)  ctl_d.dout = bus_wdata[DIO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr[4:1])
            W_DIO:   bus_rdata[DIO_W-1:0] = din_pins;
            W_CFG1:  bus_rdata[6:0] = {fifo_half, fifo_empty, fifo_full,
                                       int_flags[2], int_flags[1], int_flags[0], prom_bit};
            default: bus_rdata = '0;
        endcase
    end

    assign cfg1_val     = ctl_q.cfg1;
    assign cfg2_val     = ctl_q.cfg2;
    assign cfg3_val     = ctl_q.cfg3;
    assign dout_val     = ctl_q.dout;
    assign dout_oe      = {{HALF{ctl_q.cfg3[OE_HI]}}, {HALF{ctl_q.cfg3[OE_LO]}}};
    assign tc_clr_stb   = ctl_q.stb_tc;
    assign int1_clr_stb = ctl_q.stb_int1;
    assign int2_clr_stb = ctl_q.stb_int2;
    assign fifo_wr_stb  = ctl_q.stb_fwr;
    assign fifo_clr_stb = ctl_q.stb_fclr;
endmodule

// File: rtl/aout_bus_regs_chk.sv
module aout_bus_regs_chk #(
    parameter int NUM_CH = 6,
    parameter int DAC_W  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [4:0]              bus_addr,
    input logic                    bus_wr,
    input logic                    bus_rd,
    input logic [15:0]             cfg1_val,
    input logic [15:0]             cfg2_val,
    input logic [15:0]             cfg3_val,
    input logic [7:0]              dout_oe,
    input logic [NUM_CH*DAC_W-1:0] dac_codes,
    input logic [2:0]              int_flags,
    input logic                    tc_clr_stb,
    input logic                    int1_clr_stb,
    input logic                    int2_clr_stb,
    input logic                    fifo_wr_stb,
    input logic                    fifo_clr_stb
);
    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tc_clr_stb, int1_clr_stb, int2_clr_stb, fifo_wr_stb, fifo_clr_stb}));

    assert_bank_int1_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[4:1] == 4'd1 && cfg1_val[7]) |=> int1_clr_stb);

    assert_bank_keeps_cfg2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[4:1] == 4'd1 && cfg1_val[7]) |=> $stable(cfg2_val));

    assert_fifo_wr_not_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[4:1] == 4'd6 && !cfg1_val[7])
            |=> (fifo_wr_stb && $stable(dac_codes[DAC_W-1:0])));

    assert_fifo_clr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[4:1] == 4'd6) |=> fifo_clr_stb);

    assert_nibble_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe[0] == cfg3_val[2]) && (dout_oe[7] == cfg3_val[3]));

    assert_int1_only_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_flags[1]) |-> int1_clr_stb);

    assert_tc_only_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_flags[0]) |-> tc_clr_stb);
endmodule

bind aout_bus_regs aout_bus_regs_chk #(.NUM_CH(NUM_CH), .DAC_W(DAC_W)) u_chk (.*);

// File: tb/aout_bus_regs_tb.sv
`timescale 1ns/1ps
module aout_bus_regs_tb;
    localparam int NCH = 6;
    localparam int DW  = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [7:0] din_pins = '0;
    logic ev_tc = 0, ev_int1 = 0, ev_int2 = 0;
    logic fifo_half = 0, fifo_empty = 0, fifo_full = 0, prom_bit = 0;
    logic [15:0] cfg1_val, cfg2_val, cfg3_val;
    logic [7:0] dout_val, dout_oe;
    logic [NCH*DW-1:0] dac_codes;
    logic [2:0] int_flags;
    logic tc_clr_stb, int1_clr_stb, int2_clr_stb, fifo_wr_stb, fifo_clr_stb;

    aout_bus_regs #(.NUM_CH(NCH), .DAC_W(DW)) u_dut (.*);

    always #2.5 clk = ~clk;

    int errors = 0, checks = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    int m_cfg1, m_cfg2, m_cfg3, m_dout;
    int m_dac[NCH];
    int m_flag[3];
    int m_stb[5]; // tc, int1, int2, fifo_wr, fifo_clr

    always @(posedge clk) begin
        int w, bank, idx;
        int clr[3];
        int en[3];
        int ev[3];
        w = int'(bus_addr) / 2;
        bank = (m_cfg1 >> 7) & 1;
        for (int i = 0; i < 5; i++) m_stb[i] = 0;
        clr[0] = 0; clr[1] = 0; clr[2] = 0;
        if (!rst_n) begin
            m_cfg1 = 0; m_cfg2 = 0; m_cfg3 = 0; m_dout = 0;
            for (int i = 0; i < NCH; i++) m_dac[i] = 0;
            for (int i = 0; i < 3; i++) m_flag[i] = 0;
        end else begin
            en[0] = (m_cfg1 >> 11) & 1; en[1] = (m_cfg1 >> 14) & 1; en[2] = (m_cfg1 >> 15) & 1;
            ev[0] = ev_tc; ev[1] = ev_int1; ev[2] = ev_int2;
            if (bus_wr) begin
                if (w <= 2) begin
                    if (bank != 0) begin
                        clr[w] = 1; m_stb[w] = 1;
                    end else if (w == 0) m_dout = bus_wdata & 8'hFF;
                    else if (w == 1) m_cfg2 = bus_wdata;
                    else m_cfg3 = bus_wdata;
                end else if (w == 5) begin
                    m_cfg1 = bus_wdata;
                end else if (w >= 6) begin
                    idx = w - 6;
                    if (idx == 0 && bank == 0) m_stb[3] = 1;
                    else if (idx < NCH) m_dac[idx] = (int'(bus_wdata) + 'h800) & 'hFFF;
                end
            end
            if (bus_rd && w == 6) m_stb[4] = 1;
            for (int i = 0; i < 3; i++)
                m_flag[i] = ((m_flag[i] != 0 && clr[i] == 0) || (ev[i] != 0 && en[i] != 0)) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        int w, exp_rd;
        if (!done) begin
            chk("R2 cfg1", cfg1_val, m_cfg1);
            chk("R3 cfg2", cfg2_val, m_cfg2);
            chk("R3 cfg3", cfg3_val, m_cfg3);
            chk("R3 dout", dout_val, m_dout);
            chk("R8 oe", dout_oe, (((m_cfg3 >> 3) & 1) ? 'hF0 : 0) | (((m_cfg3 >> 2) & 1) ? 'h0F : 0));
            chk("R4 tc strobe", tc_clr_stb, m_stb[0]);
            chk("R4 int1 strobe", int1_clr_stb, m_stb[1]);
            chk("R4 int2 strobe", int2_clr_stb, m_stb[2]);
            chk("R6 fifo wr strobe", fifo_wr_stb, m_stb[3]);
            chk("R7 fifo clr strobe", fifo_clr_stb, m_stb[4]);
            chk("R10 flags", int_flags, m_flag[0] | (m_flag[1] << 1) | (m_flag[2] << 2));
            for (int i = 0; i < NCH; i++) chk("R5 dac", dac_codes[i*DW +: DW], m_dac[i]);
            w = int'(bus_addr) / 2;
            exp_rd = 0;
            if (w == 0) exp_rd = din_pins;
            if (w == 5) exp_rd = {fifo_half, fifo_empty, fifo_full, 1'b0, 1'b0, 1'b0, prom_bit}
                                 | (m_flag[2] << 3) | (m_flag[1] << 2) | (m_flag[0] << 1);
            chk("R7 rdata", bus_rdata, exp_rd);
        end
    end

    task automatic idle();
        @(negedge clk); #1;
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    endtask

    task automatic rd(input logic [4:0] a);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = 0; bus_rd = 1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        chk("R1 cfg1", cfg1_val, 0);
        chk("R1 dacs", (dac_codes == '0) ? 1 : 0, 1);
        chk("R1 flags", int_flags, 0);
        #1 rst_n = 1;
        idle();
        // R3 bank clear
        wr(5'h02, 16'h1234); wr(5'h04, 16'h0004); wr(5'h00, 16'hBEA5);
        wr(5'h04, 16'h0008); wr(5'h04, 16'h000C);
        // R10 enable flags, raise events
        wr(5'h0A, 16'hC800);
        @(negedge clk); #1; ev_tc = 1; ev_int1 = 1; ev_int2 = 1;
        idle(); @(negedge clk); #1; ev_tc = 0; ev_int1 = 0; ev_int2 = 0;
        rd(5'h0A); fifo_half = 1; prom_bit = 1;
        // R4 bank set: clear strobes, registers held
        wr(5'h0A, 16'hC880);
        wr(5'h02, 16'hFFFF); idle();
        wr(5'h00, 16'h00FF); wr(5'h04, 16'hFFFF);
        idle();
        chk("R4 cfg2 held under bank", cfg2_val, 16'h1234);
        chk("R10 flags cleared", int_flags, 0);
        // R6 channel 0 via bank, R5 other channels
        wr(5'h0C, 16'h07FF); wr(5'h0E, 16'hF800); wr(5'h16, 16'h0001);
        idle();
        chk("R5 ch0 code", dac_codes[DW-1:0], 12'hFFF);
        chk("R5 ch1 code", dac_codes[DW +: DW], 12'h000);
        wr(5'h0A, 16'h4800);
        wr(5'h0C, 16'h0123); idle();
        chk("R6 ch0 unchanged", dac_codes[DW-1:0], 12'hFFF);
        // R9 beyond last channel
        wr(5'h18, 16'h0555); wr(5'h1E, 16'h0777); idle();
        chk("R9 ch5 unchanged", dac_codes[5*DW +: DW], 12'h801);
        // R7 reads
        din_pins = 8'h3C;
        rd(5'h00); rd(5'h0C); rd(5'h0C); rd(5'h10); idle();
        // R10 event and clear in the same cycle
        wr(5'h0A, 16'h4880);
        @(negedge clk); #1; bus_wr = 0; ev_int1 = 1;
        @(negedge clk); #1; bus_addr = 5'h02; bus_wr = 1;
        @(negedge clk); #1; bus_wr = 0; ev_int1 = 0;
        idle();
        chk("R10 set wins over clear", int_flags[1], 1);
        // R11 and general mix
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); #1;
            bus_addr = 5'($urandom);
            bus_wdata = 16'($urandom);
            if ((n % 64) == 5) bus_wdata[7] = 1'b0;
            case ($urandom % 3)
                0: begin bus_wr = 1; bus_rd = 0; end
                1: begin bus_wr = 0; bus_rd = 1; end
                default: begin bus_wr = 0; bus_rd = 0; end
            endcase
            if (bus_wr && bus_addr[4:1] == 4'd5) bus_wdata[7] = bus_wdata[8];
            din_pins = 8'($urandom);
            {ev_tc, ev_int1, ev_int2} = 3'($urandom);
            {fifo_half, fifo_empty, fifo_full, prom_bit} = 4'($urandom);
            @(posedge clk); #0.5;
            chk("R11 strobes onehot",
                (tc_clr_stb + int1_clr_stb + int2_clr_stb + fifo_wr_stb + fifo_clr_stb) <= 1, 1);
        end
        idle(); idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule